// File: doc/BRIEF.md
# Addressable Serial Attenuation Control Register

This block accepts a 16-bit control frame over a three-wire serial link (data, serial clock, load strobe) and turns it into a 6-bit attenuation code for a step attenuator. Each frame holds an attenuation byte and a device-select byte. The output code changes only when the low select bits equal a strapped 3-bit device address. Several devices can therefore share one bus, and each responds only to frames sent to it.

The serial inputs are sampled by the block's own clock `clk_i` through a configurable synchronizer. A serial clock rising edge is found by comparing the synchronized level with its previous value. Each detected edge shifts one bit into a 16-bit register. A serial output returns the input stream delayed by exactly 16 serial clock edges, so a second device can hang off the first.

While the load strobe is high and the address matches, the output tracks the shift register, which behaves like a transparent latch. When the strobe falls, the output keeps the last value. While the strobe is low, shifting never disturbs the output.

Top module: `atten_serial_ctl`

## Requirements
- R1: On reset, `atten_o` is 63 (maximum attenuation, 31.5 dB in 0.5 dB steps) and `sdo_o` is 0.
- R2: Bits are shifted least significant bit first on each serial clock rising edge. The first 8 bits received form the attenuation byte and the next 8 form the select byte. The code is bits [5:0] of the attenuation byte.
- R3: A frame whose select byte bits [2:0] differ from `addr_i` leaves `atten_o` unchanged, even with the strobe high.
- R4: Select byte bits [7:3] have no effect on address matching.
- R5: Attenuation byte bits [7:6] have no effect on `atten_o`.
- R6: While `le_i` is low, `atten_o` does not change, whatever is shifted in.
- R7: While `le_i` is high and the address matches, `atten_o` follows the code bits of the shift register after each shift. After `le_i` falls, `atten_o` holds the last value.
- R8: After the n-th serial clock rising edge, `sdo_o` equals the `sdi_i` bit sampled at edge n-16.
- R9: `sdo_o` changes only in response to a serial clock rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; samples all serial inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| sdi_i | input | 1 | Serial data in, least significant bit first |
| le_i | input | 1 | Load strobe; high makes the output track the frame |
| addr_i | input | 3 | Strapped device address |
| atten_o | output | 6 | Attenuation code, 0.5 dB per step |
| sdo_o | output | 1 | Serial data out for cascading, delayed 16 edges |

## Verification
A serial clock edge and a strobe-driven latch update can land in the same `clk_i` cycle. The shift register then moves while the output is copying from it. The bench provokes this by holding `le_i` high with a matching address and clocking more bits in. A reference shift model predicts the code after every edge, and the output must equal that prediction, with no leftover value from before the edge. The same bit stream feeds a 16-deep history that predicts `sdo_o`, so the cascade output is judged during exactly those overlapping cycles.

// File: rtl/atten_ctl_pkg.sv
package atten_ctl_pkg;
  localparam int unsigned FRAME_W = 16;
  localparam int unsigned WORD_W  = 8;
  localparam int unsigned CODE_W  = 6;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned ADDR_LSB = WORD_W;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
endpackage

// File: rtl/atten_ctl_sync.sv
module atten_ctl_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/atten_ctl_shifter.sv
module atten_ctl_shifter
  import atten_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] code_o,
  output logic [ADDR_W-1:0] sel_o,
  output logic              sdo_o
);
  logic               sclk_prev_q;
  logic               sclk_rise;
  logic [FRAME_W-1:0] frame_q;
  logic               sdo_q;

  assign sclk_rise = sclk_i & ~sclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      frame_q     <= '0;
      sdo_q       <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_i;
      if (sclk_rise) begin
        // bit leaving stage 0 is the one entered 16 edges earlier
        sdo_q   <= frame_q[0];
        frame_q <= {sdi_i, frame_q[FRAME_W-1:1]};
      end
    end
  end

  assign code_o = frame_q[CODE_W-1:0];
  assign sel_o  = frame_q[ADDR_LSB +: ADDR_W];
  assign sdo_o  = sdo_q;

  assert_lsb_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise |=> frame_q[FRAME_W-1] == $past(sdi_i));
  assert_sdo_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise |=> sdo_q == $past(frame_q[0]));
  assert_sdo_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_rise |=> ($stable(sdo_q) && $stable(frame_q)));
endmodule

// File: rtl/atten_ctl_latch.sv
module atten_ctl_latch
  import atten_ctl_pkg::*;
#(
  parameter logic [CODE_W-1:0] RESET_CODE = CODE_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [ADDR_W-1:0] sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CODE_W-1:0] atten_o
);
  logic              addr_hit;
  logic [CODE_W-1:0] atten_q;

  assign addr_hit = (sel_i == addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) atten_q <= RESET_CODE;
    else if (le_i && addr_hit) atten_q <= code_i;
  end

  assign atten_o = atten_q;

  assert_hold_le_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_i |=> $stable(atten_q));
  assert_hold_mismatch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_hit |=> $stable(atten_q));
  assert_track_open_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_i && addr_hit) |=> atten_q == $past(code_i));
endmodule

// File: rtl/atten_serial_ctl.sv
module atten_serial_ctl
  import atten_ctl_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] RESET_CODE  = CODE_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              le_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CODE_W-1:0] atten_o,
  output logic              sdo_o
);
  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0]   raw_in, sync_in;
  logic [CODE_W-1:0] code;
  logic [ADDR_W-1:0] sel;

  assign raw_in = {le_i, sdi_i, sclk_i};

  atten_ctl_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw_in), .q_o(sync_in)
  );

  atten_ctl_shifter u_shift (
    .clk_i, .rst_ni,
    .sclk_i(sync_in[0]), .sdi_i(sync_in[1]),
    .code_o(code), .sel_o(sel), .sdo_o
  );

  atten_ctl_latch #(.RESET_CODE(RESET_CODE)) u_latch (
    .clk_i, .rst_ni,
    .le_i(sync_in[2]), .code_i(code), .sel_i(sel), .addr_i,
    .atten_o
  );

  assert_reset_value_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (atten_o == RESET_CODE && !sdo_o));
endmodule

// File: tb/atten_serial_ctl_bench.sv
module atten_serial_ctl_bench;
  typedef struct {
    bit         is_sdo;
    logic [7:0] val;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk = 1'b0, sdi = 1'b0, le = 1'b0;
  logic [2:0] addr = 3'b101;
  logic [5:0] atten;
  logic       sdo;

  int         n_checks = 0, n_fail = 0;
  bit         done = 1'b0;
  item_t      exp_q[$];
  bit         hist[$];
  logic [15:0] sr_model = '0;
  logic [5:0]  exp_att = 6'd63;
  logic        exp_sdo = 1'b0;
  event        sample_ev;

  always #4 clk = ~clk;

  atten_serial_ctl u_atten_serial_ctl (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdi_i(sdi), .le_i(le),
    .addr_i(addr), .atten_o(atten), .sdo_o(sdo)
  );

  function automatic bit model_hit();
    return sr_model[10:8] == addr;
  endfunction

  task automatic push_atten(string req);
    item_t it;
    it.is_sdo = 1'b0; it.val = {2'b00, exp_att}; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic push_sdo(string req);
    item_t it;
    it.is_sdo = 1'b1; it.val = {7'd0, exp_sdo}; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
    -> sample_ev;
    @(negedge clk);
  endtask

  task automatic shift_bit(input bit b);
    @(negedge clk);
    sdi = b;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    hist.push_back(b);
    sr_model = {b, sr_model[15:1]};
    if (hist.size() > 16) exp_sdo = hist[hist.size()-17];
    if (le && model_hit()) begin
      exp_att = sr_model[5:0];
      push_atten("R7");
    end else if (le) push_atten("R3");
    else push_atten("R6");
    push_sdo("R8");
    settle();
    sclk = 1'b0;
    push_sdo("R9");
    settle();
  endtask

  task automatic shift_frame(input logic [7:0] att_b, input logic [7:0] sel_b);
    logic [15:0] f;
    f = {sel_b, att_b};
    for (int i = 0; i < 16; i++) shift_bit(f[i]);
  endtask

  task automatic set_le(input bit v, input string req);
    @(negedge clk);
    le = v;
    if (v && model_hit()) exp_att = sr_model[5:0];
    push_atten(req);
    settle();
  endtask

  initial begin : monitor
    item_t it;
    logic [7:0] act;
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        act = it.is_sdo ? {7'd0, sdo} : {2'b00, atten};
        n_checks++;
        if (act !== it.val) begin
          n_fail++;
          $display("FAIL %s %s actual=%0h expected=%0h", it.req,
                   it.is_sdo ? "sdo" : "atten", act, it.val);
        end
      end
    end
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    push_atten("R1"); push_sdo("R1");
    -> sample_ev;
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R2: matching frame, code 0x15
    shift_frame(8'h15, 8'h05);
    set_le(1'b1, "R2"); set_le(1'b0, "R2");
    // R3: mismatching address
    shift_frame(8'h2A, 8'h03);
    set_le(1'b1, "R3"); set_le(1'b0, "R3");
    // R4/R5: upper select and attenuation bits set
    shift_frame(8'hC7, 8'hFD);
    set_le(1'b1, "R4"); set_le(1'b0, "R5");
    shift_frame(8'h80, 8'h05);
    set_le(1'b1, "R5"); set_le(1'b0, "R5");
    // R7: strobe held high while shifting (shift and update coincide)
    shift_frame(8'h3C, 8'hA5);
    set_le(1'b1, "R7");
    for (int i = 0; i < 10; i++) shift_bit(i[0] ^ i[2]);
    set_le(1'b0, "R7");
    for (int i = 0; i < 6; i++) shift_bit(i[1]);
    // R8: cascade stream for a second device
    shift_frame(8'h09, 8'h02);
    shift_frame(8'h36, 8'h05);
    set_le(1'b1, "R2"); set_le(1'b0, "R6");
    for (int i = 0; i < 16; i++) shift_bit(1'b0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule